// File: doc/BRIEF.md
# USB Bridge FIFO Test Controller

This block drives the slave-FIFO side of an external USB bridge chip. The chip offers two endpoint FIFOs on one 8-bit data bus, picked by a small address field. One FIFO holds bytes the host has sent, and the other takes bytes bound for the host. The controller drains every byte the host sends and keeps the most recent one for display. While a pushbutton is held, it keeps filling the outbound FIFO with a byte pattern that counts up by one each time. It keeps an 8-bit running count of the bytes moved in each direction.

Every transfer takes three clock cycles: a decision cycle, an address set-up cycle, then one strobe cycle. Draining host data always wins over streaming. A read strobe is never followed directly by a cycle that drives the bus, so the bus turns around cleanly. The bidirectional bus is shown as separate input and output buses plus an output enable, which drives the pad tri-state. Eight LEDs show one of three views, picked by slide switches: the last received byte, the received-byte count, or the sent-byte count.

Top module: `usbfifo_bridge_ctl`

## Requirements
- R1: A read strobe (`rd_stb`) is asserted only while `out_empty` is low and `fifo_addr` is 0. `fifo_addr` holds 0 for at least one cycle before the strobe. Each strobe cycle consumes exactly one byte, sampled from `bus_din` at the closing clock edge.
- R2: A write strobe (`wr_stb`) is asserted only while `in_full` is low and `fifo_addr` is 2. `bus_oe` is high only in write strobe cycles, and in those cycles `bus_dout` carries the byte being written.
- R3: When host data is waiting (`out_empty` low) during the controller's decision cycle, it starts a read, not a write, even while the button is held.
- R4: The cycle after a read strobe never has `bus_oe` high.
- R5: When `sw` equals 8'h04, `led` shows the last byte read from the host FIFO.
- R6: For any other `sw` value, `led` shows the sent-byte count when `sw[1]` is 1, and the received-byte count when `sw[1]` is 0.
- R7: Both byte counters are 8 bits wide, add one per completed strobe in their direction, and wrap from 255 to 0.
- R8: While the button is held and `in_full` is low, writes repeat. The first byte after reset is 0, and each byte is one more (mod 256) than the one before. Once the button is released, writing stops within a few cycles.
- R9: The button passes through a two-flop synchronizer, so no write strobe appears within two clock edges of the button rising.
- R10: While reset is held and just after it is released, both strobes and `bus_oe` are low, and the counters and last-byte register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw | input | 8 | Slide switches selecting the LED view |
| btn_stream | input | 1 | Raw pushbutton; streaming runs while it is high |
| out_empty | input | 1 | High when the host-to-device FIFO holds no data |
| in_full | input | 1 | High when the device-to-host FIFO cannot accept a byte |
| fifo_addr | output | 2 | FIFO select: 0 for host data, 2 for outbound data |
| rd_stb | output | 1 | Read strobe; the selected FIFO pops at the clock edge that ends the cycle |
| wr_stb | output | 1 | Write strobe; the selected FIFO pushes at the clock edge that ends the cycle |
| bus_oe | output | 1 | Pad output enable for the data bus |
| bus_din | input | 8 | Data bus as seen from the pads |
| bus_dout | output | 8 | Data driven onto the bus while `bus_oe` is high |
| led | output | 8 | LED view chosen by `sw` |

## Verification
The bench holds the button and pushes host bytes at the same moment. A design with the wrong priority would launch a write while data sat waiting. The bench fills the outbound FIFO to a small capacity to show that writing stops exactly at the full flag, then drains it and checks that the pattern picks up from the next value and does not skip or repeat one. Enough bytes are sent to wrap the received counter past 255. A counter that saturated or was wider would show a different LED value. A monitor also flags any write strobe that directly follows a read strobe, which is how a missing turnaround cycle would show up.

// File: rtl/ufb_pkg.sv
package ufb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RSET  = 3'd1,
    ST_READ  = 3'd2,
    ST_WSET  = 3'd3,
    ST_WRITE = 3'd4
  } xfer_st_e;
endpackage

// File: rtl/ufb_sync.sv
module ufb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ufb_counter.sv
module ufb_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R7: one step per strobe, wrapping modulo 2**W
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> cnt == W'($past(cnt) + 1'b1));
  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/ufb_seq.sv
module ufb_seq
  import ufb_pkg::*;
#(
  parameter int AW       = 2,
  parameter int OUT_ADDR = 0,
  parameter int IN_ADDR  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          out_empty,
  input  logic          in_full,
  input  logic          stream_req,
  output logic [AW-1:0] fifo_addr,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic          bus_oe
);
  localparam logic [AW-1:0] A_OUT = AW'(OUT_ADDR);
  localparam logic [AW-1:0] A_IN  = AW'(IN_ADDR);

  xfer_st_e      st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (!out_empty)                  st_d = ST_RSET;
        else if (stream_req && !in_full) st_d = ST_WSET;
      end
      ST_RSET:  st_d = ST_READ;
      ST_READ:  st_d = ST_IDLE;
      ST_WSET:  st_d = ST_WRITE;
      ST_WRITE: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    addr_d = addr_q;
    if (st_d == ST_RSET) addr_d = A_OUT;
    if (st_d == ST_WSET) addr_d = A_IN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= A_OUT;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
    end
  end

  assign fifo_addr = addr_q;
  assign rd_stb    = (st_q == ST_READ);
  assign wr_stb    = (st_q == ST_WRITE);
  assign bus_oe    = (st_q == ST_WRITE);

  // R1: read only with data present, address set up beforehand
  p_rd_when_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> !out_empty && fifo_addr == A_OUT);
  p_addr_setup_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_stb) |-> $past(fifo_addr) == A_OUT);
  // R2: write only with room, to the outbound address
  p_wr_when_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !in_full && fifo_addr == A_IN);
  // R4: bus turnaround after a read
  p_turnaround_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !bus_oe);
endmodule

// File: rtl/ufb_led_mux.sv
module ufb_led_mux #(
  parameter int DW         = 8,
  parameter int SW_W       = 8,
  parameter int SHOW_LAST  = 4,
  parameter int IN_SEL_BIT = 1
) (
  input  logic [SW_W-1:0] sw,
  input  logic [DW-1:0]   last_byte,
  input  logic [DW-1:0]   out_cnt,
  input  logic [DW-1:0]   in_cnt,
  output logic [DW-1:0]   led
);
  always_comb begin
    if (sw == SW_W'(SHOW_LAST))  led = last_byte;
    else if (sw[IN_SEL_BIT])     led = in_cnt;
    else                         led = out_cnt;
  end
endmodule

// File: rtl/usbfifo_bridge_ctl.sv
module usbfifo_bridge_ctl #(
  parameter int DW          = 8,
  parameter int AW          = 2,
  parameter int SW_W        = 8,
  parameter int OUT_ADDR    = 0,
  parameter int IN_ADDR     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW_W-1:0] sw,
  input  logic            btn_stream,
  input  logic            out_empty,
  input  logic            in_full,
  output logic [AW-1:0]   fifo_addr,
  output logic            rd_stb,
  output logic            wr_stb,
  output logic            bus_oe,
  input  logic [DW-1:0]   bus_din,
  output logic [DW-1:0]   bus_dout,
  output logic [DW-1:0]   led
);
  logic          rst_sync_n;
  logic          btn_s;
  logic [DW-1:0] out_cnt, in_cnt;
  logic [DW-1:0] last_q, last_d;

  ufb_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n));

  ufb_sync #(.STAGES(SYNC_STAGES)) u_btn_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(btn_stream), .q(btn_s));

  ufb_seq #(.AW(AW), .OUT_ADDR(OUT_ADDR), .IN_ADDR(IN_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .out_empty(out_empty), .in_full(in_full),
    .stream_req(btn_s), .fifo_addr(fifo_addr), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .bus_oe(bus_oe));

  ufb_counter #(.W(DW)) u_out_cnt (
    .clk(clk), .rst_n(rst_sync_n), .inc(rd_stb), .cnt(out_cnt));

  ufb_counter #(.W(DW)) u_in_cnt (
    .clk(clk), .rst_n(rst_sync_n), .inc(wr_stb), .cnt(in_cnt));

  always_comb begin
    last_d = last_q;
    if (rd_stb) last_d = bus_din;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) last_q <= '0;
    else             last_q <= last_d;
  end

  // The outbound pattern is the sent-byte count itself.
  assign bus_dout = in_cnt;

  ufb_led_mux #(.DW(DW), .SW_W(SW_W), .SHOW_LAST(4), .IN_SEL_BIT(1)) u_led (
    .sw(sw), .last_byte(last_q), .out_cnt(out_cnt), .in_cnt(in_cnt), .led(led));

  // R8: the pattern written never jumps
  p_pattern_step_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_stb |=> bus_dout == DW'($past(bus_dout) + 1'b1));
endmodule

// File: tb/usbfifo_bridge_ctl_tb_top.sv
module usbfifo_bridge_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sw = 8'h00;
  logic       btn = 1'b0;
  logic       out_empty, in_full;
  logic [1:0] fifo_addr;
  logic       rd_stb, wr_stb, bus_oe;
  logic [7:0] bus_din, bus_dout, led;

  always #10 clk = ~clk;

  // host-side FIFO models
  logic [7:0] omem [256];
  logic [7:0] imem [256];
  logic [7:0] owp = 0, orp = 0, iwp = 0, ird = 0;
  logic [7:0] in_cap = 8'd200;
  logic       host_push = 1'b0, in_drain = 1'b0;
  logic [7:0] host_byte = 8'h00;

  assign out_empty = (owp == orp);
  assign in_full   = (8'(iwp - ird) >= in_cap);
  assign bus_din   = rd_stb ? omem[orp] : 8'h00;

  always @(posedge clk) begin
    if (host_push) begin omem[owp] <= host_byte; owp <= owp + 8'd1; end
    if (rd_stb)    orp <= orp + 8'd1;
    if (wr_stb && bus_oe) begin imem[iwp] <= bus_dout; iwp <= iwp + 8'd1; end
    if (in_drain)  ird <= iwp;
  end

  usbfifo_bridge_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .sw(sw), .btn_stream(btn),
    .out_empty(out_empty), .in_full(in_full), .fifo_addr(fifo_addr),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_oe(bus_oe),
    .bus_din(bus_din), .bus_dout(bus_dout), .led(led));

  int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0, wd_fail = 0;
  logic [7:0] exp_pat = 8'h00;
  int         n_writes = 0;
  logic       prev_rd = 1'b0, ne1 = 1'b0, ne2 = 1'b0;

  // protocol monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        m_chk++;
        if (bus_dout !== exp_pat || fifo_addr !== 2'd2 || !bus_oe || in_full) begin
          m_fail++;
          $display("FAIL R8/R2: write data %0h addr %0d oe %0b full %0b, expected data %0h addr 2 oe 1 full 0",
                   bus_dout, fifo_addr, bus_oe, in_full, exp_pat);
        end
        exp_pat = exp_pat + 8'd1;
        n_writes++;
      end
      if (rd_stb) begin
        m_chk++;
        if (fifo_addr !== 2'd0 || out_empty) begin
          m_fail++;
          $display("FAIL R1: read addr %0d empty %0b, expected addr 0 empty 0", fifo_addr, out_empty);
        end
      end
      if (bus_oe && !wr_stb) begin
        m_fail++; $display("FAIL R2: bus_oe 1 outside write, expected 0");
      end
      if (prev_rd && bus_oe) begin
        m_fail++; $display("FAIL R4: bus_oe 1 right after read, expected 0");
      end
      if (wr_stb && !out_empty && ne1 && ne2) begin
        m_fail++; $display("FAIL R3: write 1 while host data waited, expected 0");
      end
      prev_rd = rd_stb;
      ne2 = ne1;
      ne1 = !out_empty;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk); host_push = 1'b1; host_byte = b;
    @(negedge clk); host_push = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic view(input logic [7:0] s);
    sw = s; #1;
  endtask

  task automatic drain_in;
    @(negedge clk); in_drain = 1'b1;
    @(negedge clk); in_drain = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + m_chk + wd_fail, n_fail + m_fail + wd_fail);
    $finish;
  endtask

  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{8'h61, 8'h0D, 8'hFF, 8'h00,
                                     8'h5A, 8'hA5, 8'h80, 8'h01};

  initial begin
    repeat (200000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    int sent;
    logic [7:0] snap;
    sent = 0;
    // R10: reset state
    settle(3);
    chk("R10 rd_stb", {7'd0, rd_stb}, 8'd0);
    chk("R10 bus_oe", {7'd0, bus_oe}, 8'd0);
    view(8'h04); chk("R10 last byte", led, 8'h00);
    rst_n = 1'b1;
    settle(4);
    view(8'h00); chk("R10 out count", led, 8'h00);
    view(8'h02); chk("R10 in count", led, 8'h00);

    // table walk: R1, R5, R6
    for (int i = 0; i < NV; i++) begin
      push_byte(VEC[i]);
      sent++;
      settle(6);
      view(8'h04); chk("R5 last byte", led, VEC[i]);
      view(8'h00); chk("R6 out count", led, 8'(sent));
    end
    view(8'h06); chk("R6 sw[1] set shows in count", led, 8'h00);
    view(8'h01); chk("R6 other view shows out count", led, 8'(sent));

    // R9: synchronizer latency
    @(negedge clk); btn = 1'b1;
    @(negedge clk); chk("R9 no early write", {7'd0, wr_stb}, 8'd0);
    @(negedge clk); chk("R9 no early write", {7'd0, wr_stb}, 8'd0);
    // R8: streaming
    settle(60);
    btn = 1'b0;
    settle(10);
    snap = iwp;
    settle(30);
    chk("R8 stops after release", iwp, snap);
    view(8'h02); chk("R8/R7 in count", led, 8'(n_writes));
    chk("R8 first byte zero", imem[0], 8'h00);
    chk("R8 stream length", 8'(iwp), 8'(n_writes));

    // R2: full flag stops writes exactly at capacity
    drain_in();
    in_cap = 8'd5;
    btn = 1'b1;
    settle(60);
    chk("R2 writes stop at full", 8'(iwp - ird), 8'd5);
    btn = 1'b0;
    settle(10);
    drain_in();
    in_cap = 8'd200;
    snap = 8'(n_writes);
    btn = 1'b1; settle(20); btn = 1'b0; settle(10);
    chk("R8 continues after full", imem[snap], snap);

    // R3: reads win while the button is held
    drain_in();
    btn = 1'b1; settle(8);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); host_push = 1'b1; host_byte = 8'hC0 + 8'(k);
    end
    @(negedge clk); host_push = 1'b0;
    sent += 4;
    settle(20);
    btn = 1'b0; settle(10);
    view(8'h04); chk("R3 last byte", led, 8'hC3);
    view(8'h00); chk("R3 out count", led, 8'(sent));

    // R7: wrap of the received counter
    for (int k = 0; k < 250; k++) begin
      @(negedge clk); host_push = 1'b1; host_byte = 8'(k);
    end
    @(negedge clk); host_push = 1'b0;
    sent += 250;
    settle(800);
    view(8'h00); chk("R7 out count wraps", led, 8'(sent));
    view(8'h04); chk("R7 last of burst", led, 8'd249);
    summary();
  end
endmodule